// File: doc/BRIEF.md
# Section Address Translation Unit

The block maps 32-bit virtual addresses to physical addresses at a granularity of 1 MB sections. A one-level table of 4096 word-sized descriptors sits in memory at a base address aligned to 16 KB. The top twelve bits of a virtual address pick one descriptor. A small fully associative lookaside buffer keeps the most recently fetched section descriptors. Requests that hit are answered straight from the buffer. Requests that miss fetch one descriptor word over a read port, then decode it and install it.

Requests enter on a valid/ready channel and results leave on a second one. Holding `rsp_ready` low freezes the result, and while the result is held no new request is taken. The unit works on one translation at a time. The memory read port uses a request channel and a data channel, both valid/ready, and the unit never has more than one read outstanding. When the translation enable input is low, each request is passed through untranslated. The flush input empties the buffer. Software must pulse it after it rewrites the table, because entries already cached keep being used until a flush.

Top module: `sect_xlate_unit`

## Requirements
- R1: When `xl_en` is 0 at the moment a request is accepted, the result appears the next cycle with `rsp_pa` equal to the virtual address, fault 0, domain, permission, cacheable and bufferable all 0. No memory read is made.
- R2: On a miss, the descriptor read address is `{tbl_base[31:14], va[31:20], 2'b00}`.
- R3: A descriptor whose bits [1:0] are 2'b10 is a section. It gives `rsp_pa = {desc[31:20], va[19:0]}`, `rsp_ap = desc[11:10]`, `rsp_domain = desc[8:5]`, `rsp_cache = desc[3]`, `rsp_buf = desc[2]` and `rsp_fault = 0`.
- R4: A descriptor of any other kind (bits [1:0] equal to 00, 01 or 11) gives `rsp_fault = 1` with every other result field 0. It is not installed in the buffer, so the next access to that section reads memory again.
- R5: A request whose section is cached is answered the cycle after acceptance, with no memory read.
- R6: On a miss, `rsp_valid` rises the cycle after the descriptor word is taken on the read data channel.
- R7: Cached entries keep their old contents after the table in memory changes. After a `tlb_flush` pulse, the next access reads the table again.
- R8: A flush that comes while a descriptor read is in progress still lets that request's result be returned, but the descriptor is not installed.
- R9: The buffer holds 8 sections and replaces them in round-robin order. After 9 distinct sections are installed following a flush, the first one is gone and the second is still present.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, every result output stays stable and `req_ready` is 0. A read request holds its address while `mem_req_ready` is 0. Out of reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R11: A request accepted in the same cycle as `tlb_flush` is treated as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xl_en | input | 1 | Translation enable; 0 passes addresses through |
| tlb_flush | input | 1 | Invalidate all cached sections |
| tbl_base | input | 32 | Table base address (bits 13:0 ignored) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_va | input | 32 | Virtual address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pa | output | 32 | Physical address |
| rsp_domain | output | 4 | Domain number |
| rsp_ap | output | 2 | Access permission field |
| rsp_cache | output | 1 | Cacheable flag |
| rsp_buf | output | 1 | Bufferable flag |
| rsp_fault | output | 1 | Translation fault |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read address |
| mem_req_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor word valid |
| mem_rsp_ready | output | 1 | Unit accepts the descriptor word |
| mem_rsp_data | input | 32 | Descriptor word |

## Verification
The hardest case to reach is a flush that lands inside a descriptor read. The read lasts only a few cycles, and its length depends on how the memory stalls. To hit it, the bench's memory model raises the flush itself one cycle after it accepts the read address, which is while the data is still pending. The bench then accesses the same section again and expects a second read. The same model varies the address-ready pattern and the data latency on every read, so the stall paths are covered throughout.

// File: rtl/sxu_pkg.sv
package sxu_pkg;
  localparam int VA_W    = 32;
  localparam int SEC_W   = 12;
  localparam int OFS_W   = VA_W - SEC_W;
  localparam int ALIGN_W = SEC_W + 2;
  localparam logic [1:0] KIND_SECTION = 2'b10;

  typedef struct packed {
    logic [SEC_W-1:0] frame;
    logic [3:0]       dom;
    logic [1:0]       perm;
    logic             cacheable;
    logic             bufferable;
  } sect_attr_t;

  typedef struct packed {
    logic [VA_W-1:0] pa;
    logic [3:0]      dom;
    logic [1:0]      perm;
    logic            cacheable;
    logic            bufferable;
    logic            fault;
  } xl_result_t;

  function automatic xl_result_t make_result(input sect_attr_t a, input logic [OFS_W-1:0] ofs);
    xl_result_t r;
    r.pa         = {a.frame, ofs};
    r.dom        = a.dom;
    r.perm       = a.perm;
    r.cacheable  = a.cacheable;
    r.bufferable = a.bufferable;
    r.fault      = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/sxu_desc_decode.sv
module sxu_desc_decode
  import sxu_pkg::*;
(
  input  logic [31:0]      desc,
  input  logic [OFS_W-1:0] ofs,
  output logic             is_sect,
  output sect_attr_t       attr,
  output xl_result_t       result
);
  logic [9:0] desc_unused;
  assign desc_unused = {desc[19:12], desc[9], desc[4]};

  assign is_sect = (desc[1:0] == KIND_SECTION);

  always_comb begin
    attr.frame      = desc[31:20];
    attr.dom        = desc[8:5];
    attr.perm       = desc[11:10];
    attr.cacheable  = desc[3];
    attr.bufferable = desc[2];
  end

  always_comb begin
    if (is_sect) begin
      result = make_result(attr, ofs);
    end else begin
      result       = '0;
      result.fault = 1'b1;
    end
  end
endmodule

// File: rtl/sxu_tlb.sv
module sxu_tlb
  import sxu_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = SEC_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output sect_attr_t       lk_attr,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  sect_attr_t       fill_attr
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  sect_attr_t         attr_q [ENTRIES];
  logic [PTR_W-1:0]   rr_ptr;
  logic               do_fill;

  assign do_fill = fill_en && !flush;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_way
    assign match[g] = vld[g] && (tag_q[g] == lk_tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[g]    <= 1'b0;
        tag_q[g]  <= '0;
        attr_q[g] <= '0;
      end else if (flush) begin
        vld[g] <= 1'b0;
      end else if (do_fill && rr_ptr == PTR_W'(g)) begin
        vld[g]    <= 1'b1;
        tag_q[g]  <= fill_tag;
        attr_q[g] <= fill_attr;
      end
    end
  end

  always_comb begin
    lk_attr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_attr = lk_attr | attr_q[i];
    end
  end
  assign lk_hit = |match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (do_fill) begin
      rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end

  p_match_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match))
    else $error("two ways match one tag");
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !lk_hit)
    else $error("hit right after flush");
endmodule

// File: rtl/sxu_walker.sv
module sxu_walker #(
  parameter int AW = 32,
  parameter int DW = 32
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          done,
  output logic [DW-1:0] done_data
);
  typedef enum logic [1:0] {W_IDLE, W_ADDR, W_DATA} wst_t;

  wst_t          st;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= W_IDLE;
      addr_q <= '0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          st     <= W_ADDR;
          addr_q <= start_addr;
        end
        W_ADDR: if (mem_req_ready) st <= W_DATA;
        W_DATA: if (mem_rsp_valid) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign busy          = (st != W_IDLE);
  assign mem_req_valid = (st == W_ADDR);
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = (st == W_DATA);
  assign done          = (st == W_DATA) && mem_rsp_valid;
  assign done_data     = mem_rsp_data;

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr))
    else $error("read request dropped or changed under stall");
endmodule

// File: rtl/sect_xlate_unit.sv
module sect_xlate_unit
  import sxu_pkg::*;
#(
  parameter int TLB_ENTRIES = 8
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xl_en,
  input  logic        tlb_flush,
  input  logic [31:0] tbl_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_pa,
  output logic [3:0]  rsp_domain,
  output logic [1:0]  rsp_ap,
  output logic        rsp_cache,
  output logic        rsp_buf,
  output logic        rsp_fault,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  output logic        mem_rsp_ready,
  input  logic [31:0] mem_rsp_data
);
  localparam logic [VA_W-1:0] BASE_MASK = ~VA_W'((1 << ALIGN_W) - 1);

  logic             acc, hit, lk_hit;
  sect_attr_t       lk_attr;
  logic             walk_start, walk_busy, walk_done;
  logic [31:0]      walk_data, walk_addr;
  logic             dec_sect;
  sect_attr_t       dec_attr;
  xl_result_t       dec_result;
  logic             fill_en;
  xl_result_t       rsp_q;
  logic             rsp_valid_q;
  logic [OFS_W-1:0] ofs_q;
  logic             cancel_q;

  assign req_ready  = !walk_busy && (!rsp_valid_q || rsp_ready);
  assign acc        = req_valid && req_ready;
  assign hit        = lk_hit && !tlb_flush;
  assign walk_start = acc && xl_en && !hit;
  assign walk_addr  = (tbl_base & BASE_MASK) | {{(VA_W-ALIGN_W){1'b0}}, req_va[VA_W-1:OFS_W], 2'b00};
  assign fill_en    = walk_done && dec_sect && !cancel_q && !tlb_flush;

  sxu_tlb #(.ENTRIES(TLB_ENTRIES), .TAG_W(SEC_W)) u_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tlb_flush),
    .lk_tag    (req_va[VA_W-1:OFS_W]),
    .lk_hit    (lk_hit),
    .lk_attr   (lk_attr),
    .fill_en   (fill_en),
    .fill_tag  (walk_addr_tag_q),
    .fill_attr (dec_attr)
  );

  logic [SEC_W-1:0] walk_addr_tag_q;

  sxu_walker #(.AW(VA_W), .DW(32)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (walk_start),
    .start_addr    (walk_addr),
    .busy          (walk_busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data),
    .done          (walk_done),
    .done_data     (walk_data)
  );

  sxu_desc_decode u_dec (
    .desc    (walk_data),
    .ofs     (ofs_q),
    .is_sect (dec_sect),
    .attr    (dec_attr),
    .result  (dec_result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q     <= 1'b0;
      rsp_q           <= '0;
      ofs_q           <= '0;
      walk_addr_tag_q <= '0;
      cancel_q        <= 1'b0;
    end else begin
      if (acc) begin
        ofs_q           <= req_va[OFS_W-1:0];
        walk_addr_tag_q <= req_va[VA_W-1:OFS_W];
        if (!xl_en) begin
          rsp_valid_q <= 1'b1;
          rsp_q       <= '0;
          rsp_q.pa    <= req_va;
        end else if (hit) begin
          rsp_valid_q <= 1'b1;
          rsp_q       <= make_result(lk_attr, req_va[OFS_W-1:0]);
        end else begin
          rsp_valid_q <= 1'b0;
        end
      end else if (walk_done) begin
        rsp_valid_q <= 1'b1;
        rsp_q       <= dec_result;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end

      if (walk_start) begin
        cancel_q <= 1'b0;
      end else if (tlb_flush && walk_busy) begin
        cancel_q <= 1'b1;
      end
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_pa     = rsp_q.pa;
  assign rsp_domain = rsp_q.dom;
  assign rsp_ap     = rsp_q.perm;
  assign rsp_cache  = rsp_q.cacheable;
  assign rsp_buf    = rsp_q.bufferable;
  assign rsp_fault  = rsp_q.fault;

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)
      && $stable(rsp_domain) && $stable(rsp_ap))
    else $error("result changed while stalled");
  p_hit_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && xl_en && hit |=> rsp_valid && !mem_req_valid)
    else $error("hit not answered next cycle");
  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !xl_en |=> rsp_valid && rsp_pa == $past(req_va) && !rsp_fault && !mem_req_valid)
    else $error("bypass result wrong");
  p_fault_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pa == '0 && rsp_domain == '0 && !rsp_cache && !rsp_buf)
    else $error("fault result carries data");
  p_no_accept_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready)
    else $error("request taken during walk");
endmodule

// File: tb/tb_sect_xlate_unit.sv
`timescale 1ns/1ps
module tb_sect_xlate_unit;
  localparam logic [31:0] BASE = 32'h0004_C000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, xl_en, tlb_flush, req_valid, req_ready, rsp_valid, rsp_ready;
  logic [31:0] tbl_base, req_va, rsp_pa, mem_req_addr, mem_rsp_data;
  logic [3:0]  rsp_domain;
  logic [1:0]  rsp_ap;
  logic        rsp_cache, rsp_buf, rsp_fault;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic        flush_tb, flush_walk;

  assign tlb_flush = flush_tb | flush_walk;

  sect_xlate_unit dut (
    .clk(clk), .rst_n(rst_n), .xl_en(xl_en), .tlb_flush(tlb_flush), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_domain(rsp_domain),
    .rsp_ap(rsp_ap), .rsp_cache(rsp_cache), .rsp_buf(rsp_buf), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0, n_err = 0;
  int cyc_ct, rd_cnt, t_hs, ver, mdly;
  bit arm_wf = 1'b0;
  logic [1:0]  mst;
  logic [31:0] maddr, last_addr;

  function automatic logic [31:0] mk_desc(input logic [11:0] idx, input int v);
    logic [31:0] d, t;
    d = '0;
    t = 32'(idx) * 32'd7 + 32'(v) * 32'd291 + 32'd21;
    d[31:20] = t[11:0];
    d[11:10] = idx[1:0] ^ 2'(v);
    d[8:5]   = idx[5:2];
    d[4]     = 1'b1;
    d[3]     = idx[6];
    d[2]     = idx[7] ^ 1'(v);
    if (idx % 11 == 7)       d[1:0] = 2'b01;
    else if (idx % 13 == 5)  d[1:0] = 2'b11;
    else if (idx % 17 == 3)  d[1:0] = 2'b00;
    else                     d[1:0] = 2'b10;
    return d;
  endfunction

  function automatic logic [40:0] expect_xl(input logic [31:0] va, input int v, input bit en);
    logic [31:0] d;
    if (!en) return {va, 9'b0};
    d = mk_desc(va[31:20], v);
    if (d[1:0] != 2'b10) return {40'b0, 1'b1};
    return {d[31:20], va[19:0], d[8:5], d[11:10], d[3], d[2], 1'b0};
  endfunction

  // memory model: stalls the address channel, varies data latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_ct <= 0; rd_cnt <= 0; t_hs <= 0; mdly <= 0; mst <= 2'd0;
      mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
      maddr <= '0; last_addr <= '0; flush_walk <= 1'b0;
    end else begin
      cyc_ct     <= cyc_ct + 1;
      flush_walk <= arm_wf && mem_req_valid && mem_req_ready;
      case (mst)
        2'd0: begin
          mem_req_ready <= (cyc_ct % 3) != 1;
          if (mem_req_valid && mem_req_ready) begin
            maddr <= mem_req_addr; last_addr <= mem_req_addr;
            rd_cnt <= rd_cnt + 1; mdly <= rd_cnt % 3;
            mst <= 2'd1; mem_req_ready <= 1'b0;
          end
        end
        2'd1: if (mdly == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mk_desc(12'((maddr - BASE) >> 2), ver);
          mst <= 2'd2;
        end else mdly <= mdly - 1;
        default: if (mem_rsp_ready) begin
          mem_rsp_valid <= 1'b0; t_hs <= cyc_ct; mst <= 2'd0;
        end
      endcase
    end
  end

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] va, input bit en, output logic [40:0] got,
                       output int lat, output int t_seen);
    @(negedge clk); req_valid = 1'b1; req_va = va; xl_en = en;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0; lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    t_seen = cyc_ct;
    got = {rsp_pa, rsp_domain, rsp_ap, rsp_cache, rsp_buf, rsp_fault};
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush_tb = 1'b1;
    @(negedge clk); flush_tb = 1'b0;
  endtask

  function automatic logic [31:0] va_of(input logic [11:0] idx, input int k);
    return {idx, 20'(k * 40503 + 7)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [40:0] got;
    int lat, ts, r0;
    logic [31:0] va;
    rst_n = 1'b0; xl_en = 1'b0; flush_tb = 1'b0; req_valid = 1'b0; req_va = '0;
    rsp_ready = 1'b1; tbl_base = BASE; ver = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R10", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk("R10", "reset req_ready", 64'(req_ready), 64'd1);

    // R1 bypass
    for (int i = 0; i < 16; i++) begin
      va = 32'(i) * 32'h1357_9BDF;
      r0 = rd_cnt;
      xlate(va, 1'b0, got, lat, ts);
      chk("R1", "bypass result", 64'(got), 64'(expect_xl(va, ver, 1'b0)));
      chk("R1", "bypass latency", 64'(lat), 64'd1);
      chk("R1", "bypass no read", 64'(rd_cnt), 64'(r0));
    end

    // R2 R3 R4 R6 sweep of distinct sections
    pulse_flush();
    for (int i = 0; i < 96; i++) begin
      logic [11:0] idx;
      idx = 12'(i * 53 + 11);
      va = va_of(idx, i);
      r0 = rd_cnt;
      xlate(va, 1'b1, got, lat, ts);
      chk("R2", "descriptor address", 64'(last_addr), 64'(BASE + 32'(idx) * 4));
      chk("R6", "one read on miss", 64'(rd_cnt), 64'(r0 + 1));
      chk("R6", "valid after data", 64'(ts), 64'(t_hs + 1));
      chk("R3", "decoded result", 64'(got), 64'(expect_xl(va, ver, 1'b1)));
    end

    // R4 non-section kinds fault and stay uncached
    pulse_flush();
    for (int k = 0; k < 3; k++) begin
      logic [11:0] idx;
      idx = (k == 0) ? 12'd7 : (k == 1) ? 12'd18 : 12'd5;
      for (int rep = 0; rep < 2; rep++) begin
        va = va_of(idx, rep + 3);
        r0 = rd_cnt;
        xlate(va, 1'b1, got, lat, ts);
        chk("R4", "fault result", 64'(got), 64'(expect_xl(va, ver, 1'b1)));
        chk("R4", "fault fault bit", 64'(got[0]), 64'd1);
        chk("R4", "fault rereads", 64'(rd_cnt), 64'(r0 + 1));
      end
    end

    // R5 hits after filling 8 sections
    pulse_flush();
    for (int j = 0; j < 8; j++) xlate(va_of(12'(64 * j + 1), j), 1'b1, got, lat, ts);
    for (int j = 0; j < 8; j++) begin
      va = va_of(12'(64 * j + 1), j + 50);
      r0 = rd_cnt;
      xlate(va, 1'b1, got, lat, ts);
      chk("R5", "hit result", 64'(got), 64'(expect_xl(va, ver, 1'b1)));
      chk("R5", "hit latency", 64'(lat), 64'd1);
      chk("R5", "hit no read", 64'(rd_cnt), 64'(r0));
    end

    // R9 ninth fill evicts the oldest
    r0 = rd_cnt;
    xlate(va_of(12'd514, 1), 1'b1, got, lat, ts);
    chk("R9", "ninth section read", 64'(rd_cnt), 64'(r0 + 1));
    r0 = rd_cnt;
    xlate(va_of(12'd65, 9), 1'b1, got, lat, ts);
    chk("R9", "second section kept", 64'(rd_cnt), 64'(r0));
    r0 = rd_cnt;
    xlate(va_of(12'd1, 9), 1'b1, got, lat, ts);
    chk("R9", "first section evicted", 64'(rd_cnt), 64'(r0 + 1));

    // R7 stale entries until flush
    pulse_flush();
    xlate(va_of(12'd129, 2), 1'b1, got, lat, ts);
    ver = 1;
    r0 = rd_cnt;
    va = va_of(12'd129, 4);
    xlate(va, 1'b1, got, lat, ts);
    chk("R7", "stale entry used", 64'(got), 64'(expect_xl(va, 0, 1'b1)));
    chk("R7", "stale no read", 64'(rd_cnt), 64'(r0));
    pulse_flush();
    xlate(va, 1'b1, got, lat, ts);
    chk("R7", "fresh after flush", 64'(got), 64'(expect_xl(va, 1, 1'b1)));
    chk("R7", "flush forces read", 64'(rd_cnt), 64'(r0 + 1));
    ver = 0;

    // R8 flush inside the walk cancels the fill
    pulse_flush();
    arm_wf = 1'b1;
    va = va_of(12'd193, 5);
    r0 = rd_cnt;
    xlate(va, 1'b1, got, lat, ts);
    arm_wf = 1'b0;
    chk("R8", "result still returned", 64'(got), 64'(expect_xl(va, ver, 1'b1)));
    xlate(va, 1'b1, got, lat, ts);
    chk("R8", "no fill after cancel", 64'(rd_cnt), 64'(r0 + 2));

    // R11 flush in the accept cycle turns a hit into a miss
    va = va_of(12'd257, 6);
    xlate(va, 1'b1, got, lat, ts);
    r0 = rd_cnt;
    @(negedge clk); req_valid = 1'b1; req_va = va; flush_tb = 1'b1;
    @(negedge clk); req_valid = 1'b0; flush_tb = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk("R11", "flush with request misses", 64'(rd_cnt), 64'(r0 + 1));
    chk("R11", "result", 64'({rsp_pa, rsp_domain, rsp_ap, rsp_cache, rsp_buf, rsp_fault}),
        64'(expect_xl(va, ver, 1'b1)));

    // R10 result held under back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    va = va_of(12'd257, 11);
    req_valid = 1'b1; req_va = va;
    @(negedge clk); req_valid = 1'b0;
    for (int w = 0; w < 4; w++) begin
      chk("R10", "held valid", 64'(rsp_valid), 64'd1);
      chk("R10", "held result", 64'(rsp_pa), 64'(expect_xl(va, ver, 1'b1) >> 9));
      chk("R10", "no accept while held", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10", "released", 64'(rsp_valid), 64'd0);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule